// File: doc/BRIEF.md
# Stereo PDM Microphone to 8-bit PCM Converter

This block clocks a pair of pulse-density-modulated microphones that share one data wire and turns their two bit streams into 8-bit samples. It divides the system clock into a square microphone clock, picks the left-channel bit off the shared wire when that clock rises and the right-channel bit when it falls, and keeps, for each channel, a running count of the ones among that channel's most recent 255 bits.

Every 32 microphone clock periods both running counts are copied into two output registers, which a CPU register interface reads directly, and a one-cycle strobe marks the update. The microphone clock rate is the system clock divided by twice the `HALF_CYC` parameter. At a 50 MHz system clock, settings of 5 to 25 span roughly 5 MHz down to 1 MHz, and the higher rates give better quality.

The clock generator is a two-state machine. `CK_LOW` drives the microphone clock low and `CK_HIGH` drives it high. The transition `CK_LOW -> CK_HIGH` (the rise) fires when the phase counter reaches `HALF_CYC-1` and captures the left bit. The transition `CK_HIGH -> CK_LOW` (the fall) fires under the same condition and captures the right bit. Reset forces `CK_LOW`.

Top module: `pdm_mic_pcm`

## Requirements
- R1: `mic_clk` stays high for exactly `HALF_CYC` system clocks and low for exactly `HALF_CYC` system clocks in every period after the first one following reset.
- R2: While `rst` is high, `mic_clk` is 0, both samples are 0 and `pcm_valid` is 0. Reset also empties both bit histories, so the first samples after reset count only bits received after reset.
- R3: The left bit is the value of `mic_data` at the system clock edge where `mic_clk` goes from 0 to 1. The right bit is its value at the edge where `mic_clk` goes from 1 to 0.
- R4: Each channel's count equals the number of 1 bits among that channel's most recent 255 bits, or among all of its bits since reset if fewer than 255 have arrived.
- R5: The count never wraps. A run of 255 or more consecutive ones holds it at 255, because the incoming 1 and the departing 1 cancel in the same update.
- R6: `pcm_valid` is high for exactly one system clock, one clock after every 32nd fall of `mic_clk` counted from reset. In that same cycle `pcm_left` and `pcm_right` present both channels' counts, including the right bit captured at that fall.
- R7: `pcm_left` and `pcm_right` do not change in any cycle where `pcm_valid` is low.
- R8: The two channels are independent. Bits captured on falls never change `pcm_left`, and bits captured on rises never change `pcm_right`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mic_data | input | 1 | Shared PDM data: left channel sampled at the rise, right channel at the fall |
| mic_clk | output | 1 | Generated microphone clock |
| pcm_left | output | 8 | Latest left-channel sample |
| pcm_right | output | 8 | Latest right-channel sample |
| pcm_valid | output | 1 | One-cycle strobe marking new samples |

## Verification
Two things can happen in the same window update: the newest bit enters the count and the oldest bit leaves it. That update can also be the right-channel update that the sample latch reads on the very next cycle. The bench provokes the first collision by holding the left bits at 1 for more than 255 periods, so that every later update adds a 1 and drops a 1 at once. It provokes the second by comparing every strobe against a model that includes the right bit captured at the triggering fall, across all-zero, saturating, alternating, quarter-density and pseudo-random patterns. A scoreboard queue of expected sample pairs judges each strobe, and the strobe's position relative to the fall is checked as well.

// File: rtl/pdm_mic_pkg.sv
package pdm_mic_pkg;
    typedef enum logic {
        CK_LOW  = 1'b0,
        CK_HIGH = 1'b1
    } ck_state_t;

    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;
    localparam int N_CH     = 2;
endpackage

// File: rtl/pdm_clk_fsm.sv
module pdm_clk_fsm
    import pdm_mic_pkg::*;
#(
    parameter int HALF_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    output logic mic_clk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(HALF_CYC - 1);

    ck_state_t state_q, state_d;
    logic [PW-1:0] ph_q;
    logic ph_end;

    assign ph_end = (ph_q == PH_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_LOW:  if (ph_end) state_d = CK_HIGH;
            CK_HIGH: if (ph_end) state_d = CK_LOW;
            default: state_d = CK_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CK_LOW;
            ph_q    <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_end ? '0 : ph_q + 1'b1;
        end
    end

    always_comb begin
        mic_clk  = 1'b0;
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        unique case (state_q)
            CK_LOW: begin
                mic_clk  = 1'b0;
                rise_evt = ph_end;
            end
            CK_HIGH: begin
                mic_clk  = 1'b1;
                fall_evt = ph_end;
            end
            default: mic_clk = 1'b0;
        endcase
    end

    a_r1_toggle_at_phase_end: assert property (@(posedge clk) disable iff (rst)
        (mic_clk != $past(mic_clk)) |-> ($past(ph_q) == PH_LAST));
    a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rise_evt && fall_evt));
endmodule

// File: rtl/pdm_window_count.sv
module pdm_window_count #(
    parameter int WIN = 255,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_evt,
    input  logic          bit_in,
    output logic [CW-1:0] count
);
    logic [WIN-1:0] hist_q;
    logic [CW-1:0]  cnt_q;
    logic           oldest;

    assign oldest = hist_q[WIN-1];
    assign count  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (bit_evt) begin
            hist_q <= {hist_q[WIN-2:0], bit_in};
            cnt_q  <= cnt_q + CW'(bit_in) - CW'(oldest);
        end
    end

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        bit_evt |=> (({1'b0, cnt_q} == {1'b0, $past(cnt_q)})
                  || ({1'b0, cnt_q} == {1'b0, $past(cnt_q)} + 1'b1)
                  || ({1'b0, cnt_q} + 1'b1 == {1'b0, $past(cnt_q)})));
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_evt |=> $stable(cnt_q));
endmodule

// File: rtl/pdm_mic_pcm.sv
module pdm_mic_pcm
    import pdm_mic_pkg::*;
#(
    parameter int HALF_CYC = 5,
    parameter int SAMPLE_W = 8,
    parameter int DEC      = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mic_data,
    output logic                mic_clk,
    output logic [SAMPLE_W-1:0] pcm_left,
    output logic [SAMPLE_W-1:0] pcm_right,
    output logic                pcm_valid
);
    localparam int WIN = (1 << SAMPLE_W) - 1;
    localparam int DW  = (DEC > 1) ? $clog2(DEC) : 1;
    localparam logic [DW-1:0] DEC_LAST = DW'(DEC - 1);

    logic rise_evt, fall_evt;
    logic [N_CH-1:0] ch_evt;
    logic [SAMPLE_W-1:0] ch_cnt [N_CH];
    logic [DW-1:0] dec_q;
    logic latch_q;
    logic [SAMPLE_W-1:0] left_q, right_q;

    pdm_clk_fsm #(.HALF_CYC(HALF_CYC)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .mic_clk  (mic_clk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    assign ch_evt[CH_LEFT]  = rise_evt;
    assign ch_evt[CH_RIGHT] = fall_evt;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pdm_window_count #(.WIN(WIN), .CW(SAMPLE_W)) u_win (
            .clk     (clk),
            .rst     (rst),
            .bit_evt (ch_evt[c]),
            .bit_in  (mic_data),
            .count   (ch_cnt[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q   <= '0;
            latch_q <= 1'b0;
        end else begin
            latch_q <= fall_evt && (dec_q == DEC_LAST);
            if (fall_evt) dec_q <= (dec_q == DEC_LAST) ? '0 : dec_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q    <= '0;
            right_q   <= '0;
            pcm_valid <= 1'b0;
        end else begin
            pcm_valid <= latch_q;
            if (latch_q) begin
                left_q  <= ch_cnt[CH_LEFT];
                right_q <= ch_cnt[CH_RIGHT];
            end
        end
    end

    assign pcm_left  = left_q;
    assign pcm_right = right_q;

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid);
    a_r6_strobe_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(pcm_valid) |-> $past(fall_evt, 2));
    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        !pcm_valid |-> ($stable(pcm_left) && $stable(pcm_right)));
    a_r2_quiet_reset: assert property (@(posedge clk)
        rst |=> (!pcm_valid && pcm_left == '0 && pcm_right == '0 && !mic_clk));
endmodule

// File: tb/sim_pdm_mic_pcm.sv
module sim_pdm_mic_pcm;
    localparam int HALF = 3;
    localparam int WIN  = 255;
    localparam int DEC  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mic_data = 1'b0;
    logic mic_clk;
    logic [7:0] pcm_left, pcm_right;
    logic pcm_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] exp_q [$];
    bit lbits [$];
    bit rbits [$];

    always #10 clk = ~clk;

    pdm_mic_pcm #(.HALF_CYC(HALF), .SAMPLE_W(8), .DEC(DEC)) u0 (
        .clk       (clk),
        .rst       (rst),
        .mic_data  (mic_data),
        .mic_clk   (mic_clk),
        .pcm_left  (pcm_left),
        .pcm_right (pcm_right),
        .pcm_valid (pcm_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int window_ones(ref bit b [$]);
        int s = 0;
        int n = b.size();
        int lo = (n > WIN) ? n - WIN : 0;
        for (int i = lo; i < n; i++) s += int'(b[i]);
        return s;
    endfunction

    // Pattern source: run selects stimulus family, p is the period, ch 0=left 1=right
    function automatic bit pat(input int run, input int p, input int ch, input logic [15:0] lf);
        if (run == 0) begin
            if (p < 64) return 1'b0;
            return (ch == 0);
        end
        if (p < 128) return (ch == 0) ? p[0] : (p % 4 == 0);
        return (ch == 0) ? lf[0] : 1'b1;
    endfunction

    // Driver: presents bits around each mic_clk edge and pushes expected samples
    task automatic drive_run(input int run, input int periods);
        logic [15:0] lf = 16'hACE1;
        lbits.delete();
        rbits.delete();
        mic_data = pat(run, 0, 0, lf);
        for (int p = 0; p < periods; p++) begin
            @(posedge mic_clk);
            #1;
            lbits.push_back(mic_data);
            mic_data = pat(run, p, 1, lf);
            @(negedge mic_clk);
            #1;
            rbits.push_back(mic_data);
            if ((p + 1) % DEC == 0)
                exp_q.push_back({8'(window_ones(lbits)), 8'(window_ones(rbits))});
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            mic_data = pat(run, p + 1, 0, lf);
        end
    endtask

    // Monitor: scoreboard compare, strobe width and latency, clock phase lengths
    int since_fall = 100;
    int run_len = 0;
    int toggles = 0;
    logic prev_clk = 1'b0;
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mic_clk != prev_clk) begin
                if (toggles > 0 && toggles < 8) check("R1 phase length", run_len, HALF);
                toggles++;
                run_len = 1;
            end else run_len++;
            since_fall = (prev_clk && !mic_clk) ? 0 : since_fall + 1;
            if (pcm_valid) begin
                logic [15:0] e;
                check("R6 strobe one cycle after fall", since_fall, 1);
                if (prev_valid) check("R6 strobe width", 2, 1);
                if (exp_q.size() == 0) check("R6 unexpected strobe", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    check("R4 R5 left sample", pcm_left, e[15:8]);
                    check("R4 R8 right sample", pcm_right, e[7:0]);
                end
            end
        end else begin
            toggles = 0;
            run_len = 0;
        end
        prev_clk = mic_clk;
        prev_valid = pcm_valid;
    end

    // R7: samples hold between strobes
    logic [15:0] held = 16'h0;
    always @(negedge clk) begin
        if (!rst && !pcm_valid && {pcm_left, pcm_right} != held)
            check("R7 hold between strobes", {pcm_left, pcm_right}, held);
        held = {pcm_left, pcm_right};
    end

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                check("watchdog expired", 1, 0);
                done = 1'b1;
            end
            begin
                repeat (4) @(posedge clk);
                @(negedge clk);
                check("R2 reset mic_clk low", mic_clk, 0);
                check("R2 reset left zero", pcm_left, 0);
                check("R2 reset right zero", pcm_right, 0);
                check("R2 reset valid low", pcm_valid, 0);
                rst = 1'b0;
                // R3 R4 R5: zeros, then left saturating ones against right zeros
                drive_run(0, 384);
                repeat (4 * HALF) @(posedge clk);
                check("R6 all samples seen run0", exp_q.size(), 0);
                check("R5 left saturated", pcm_left, 255);
                check("R8 right untouched by left ones", pcm_right, 0);
                @(negedge clk);
                rst = 1'b1;
                repeat (3) @(posedge clk);
                @(negedge clk);
                check("R2 mid-run reset left zero", pcm_left, 0);
                check("R2 mid-run reset mic_clk low", mic_clk, 0);
                rst = 1'b0;
                // R2 history cleared: run1 model starts empty; R4 R8 mixed patterns
                drive_run(1, 256);
                repeat (4 * HALF) @(posedge clk);
                check("R6 all samples seen run1", exp_q.size(), 0);
                done = 1'b1;
            end
        join_any
        wait (done);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule